// File: doc/BRIEF.md
# Dual Page-Buffer Serial Access Slave

This block is the serial front end of a page-oriented storage device. It gives an SPI host direct byte access to two independent 264-byte SRAM page buffers, and it also answers the status-byte command. The host selects the block by pulling chip select low, clocks in an 8-bit command code and a command-specific frame of address bits, and then streams data bytes into or out of the chosen buffer. The flash array and all page program, erase and transfer operations live elsewhere. The two status flags, ready and compare-miss, arrive on ports from that logic.

The serial pins are oversampled by a faster system clock. Chip select, the serial clock and the data input are synchronised into that domain and edge-detected there. Input bits are taken on each rising serial-clock edge, and output bits are launched on each falling edge. So a host may idle the clock either low (mode 0) or high (mode 3). Every transfer is MSB first. A buffer position that a burst does not reach keeps its old byte. Addresses roll from the last byte back to byte 0.

Top module: `spi_pagebuf_slave`

## Requirements
- R1: While chip select is high, `spi_so_oe` is 0, and serial clock and data activity change no buffer content.
- R2: Data bits are taken on rising serial-clock edges, and `spi_so` changes only on falling edges. Hosts idling the clock low (mode 0) and high (mode 3) both work.
- R3: Command 0x84 writes buffer A and 0x87 writes buffer B. The command is followed by 15 ignored bits, a 9-bit start address (sent MSB first, last in the 24-bit field) and then data bytes, each MSB first.
- R4: Commands 0x54 and 0xD4 read buffer A, and 0x56 and 0xD6 read buffer B. The frame is 15 ignored bits, a 9-bit address and 8 don't-care bits. The first data bit (the MSB) is driven on the falling edge after the 40th rising edge.
- R5: Both reads and writes that step past byte 263 continue at byte 0 of the same buffer.
- R6: A byte is stored only after all 8 of its bits have been received. A partial byte at a chip-select rise is dropped. Positions a burst does not reach keep their contents.
- R7: Commands 0x57 and 0xD7 return a status byte. The first bit is driven on the falling edge after the 8th rising edge. Bit 7 is ready, bit 6 is compare-miss, bits 5:3 are 011 and bits 2:0 are 000.
- R8: The status byte repeats for as long as chip select stays low. The flags are re-sampled when bit 7 of each repetition is driven, and are held for the rest of that byte.
- R9: Any other command code leaves `spi_so_oe` at 0 and buffers untouched until chip select goes high.
- R10: A start address from 264 to 511 is treated as address 0.
- R11: A write to one buffer never changes the other buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for `spi_so` (0 means high impedance) |
| status_ready | input | 1 | Ready flag (1 means not busy), synchronous to `clk` |
| status_cmp_miss | input | 1 | Last compare result (1 means mismatch), synchronous to `clk` |

## Verification
Each pin change takes two synchroniser stages and one registered stage, so a falling serial-clock edge shows up on `spi_so` at most about three system cycles later. The bench holds each serial-clock half period for six system cycles and samples `spi_so` just before it raises the clock, as a host would. That keeps every sample well after the launching edge. A stored byte only becomes visible through a later read command, so write results are checked by reading back against a bench model of both buffers. Status flag changes are applied in the middle of a byte, so the expected value moves only at the next repetition.

// File: rtl/spi_pb_pkg.sv
package spi_pb_pkg;

    localparam int NBUF = 2;

    localparam logic [7:0] OP_WR_A  = 8'h84;
    localparam logic [7:0] OP_WR_B  = 8'h87;
    localparam logic [7:0] OP_RD_A0 = 8'h54;
    localparam logic [7:0] OP_RD_A1 = 8'hD4;
    localparam logic [7:0] OP_RD_B0 = 8'h56;
    localparam logic [7:0] OP_RD_B1 = 8'hD6;
    localparam logic [7:0] OP_ST_0  = 8'h57;
    localparam logic [7:0] OP_ST_1  = 8'hD7;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_IGNORE
    } phase_e;

endpackage

// File: rtl/spi_pb_sync.sv
module spi_pb_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] dly_o
);

    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain_q [DEPTH];
    logic [W-1:0] chain_d [DEPTH];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign lvl_o = chain_q[STAGES-1];
    assign dly_o = chain_q[STAGES];

endmodule

// File: rtl/spi_pb_ram.sv
module spi_pb_ram #(
    parameter int DEPTH = 264,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

    assert_waddr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr <= LAST));
    assert_raddr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        raddr <= LAST);

endmodule

// File: rtl/spi_pb_ctrl.sv
module spi_pb_ctrl
    import spi_pb_pkg::*;
#(
    parameter int          DEPTH      = 264,
    parameter int          AW         = $clog2(DEPTH),
    parameter int          RSV_BITS   = 15,
    parameter int          DUMMY_BITS = 8,
    parameter logic [2:0]  DENSITY    = 3'b011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          si,
    input  logic          ready,
    input  logic          cmp_miss,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] raddr,
    output logic          rsel,
    output logic          we,
    output logic          wsel,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic          so_o,
    output logic          oe_o
);

    localparam int FIELD = RSV_BITS + AW;
    localparam int CW    = $clog2(FIELD + 1);
    localparam int SHW   = (AW > 8) ? AW : 8;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
        logic [SHW-1:0]  sh;
        logic [2:0]      bc;
        logic [AW-1:0]   addr;
        logic            sel;
        logic            wr;
        logic            so;
        logic            oe;
        logic [7:0]      shadow;
        logic            we;
        logic            wsel;
        logic [AW-1:0]   waddr;
        logic [7:0]      wdata;
    } ctrl_s;

    ctrl_s state_d, state_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        logic [SHW-1:0] shifted;
        logic [7:0]     live;
        logic [AW-1:0]  a;

        shifted = {state_q.sh[SHW-2:0], si};
        live    = {ready, cmp_miss, DENSITY, 3'b000};
        a       = shifted[AW-1:0];

        state_d    = state_q;
        state_d.we = 1'b0;

        if (cs_hi) begin
            state_d.ph  = PH_OPC;
            state_d.cnt = '0;
            state_d.bc  = '0;
            state_d.oe  = 1'b0;
            state_d.so  = 1'b0;
        end else if (sck_rise) begin
            unique case (state_q.ph)
                PH_OPC: begin
                    state_d.sh = shifted;
                    if (state_q.cnt == CW'(7)) begin
                        state_d.cnt = '0;
                        state_d.bc  = '0;
                        unique case (shifted[7:0])
                            OP_WR_A:  begin state_d.ph = PH_ADDR; state_d.wr = 1'b1; state_d.sel = 1'b0; end
                            OP_WR_B:  begin state_d.ph = PH_ADDR; state_d.wr = 1'b1; state_d.sel = 1'b1; end
                            OP_RD_A0,
                            OP_RD_A1: begin state_d.ph = PH_ADDR; state_d.wr = 1'b0; state_d.sel = 1'b0; end
                            OP_RD_B0,
                            OP_RD_B1: begin state_d.ph = PH_ADDR; state_d.wr = 1'b0; state_d.sel = 1'b1; end
                            OP_ST_0,
                            OP_ST_1:  state_d.ph = PH_STAT;
                            default:  state_d.ph = PH_IGNORE;
                        endcase
                    end else begin
                        state_d.cnt = state_q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    state_d.sh = shifted;
                    if (state_q.cnt == CW'(FIELD - 1)) begin
                        state_d.addr = (a > LAST) ? '0 : a;
                        state_d.cnt  = '0;
                        state_d.bc   = '0;
                        state_d.ph   = state_q.wr ? PH_WDATA : PH_DUMMY;
                    end else begin
                        state_d.cnt = state_q.cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (state_q.cnt == CW'(DUMMY_BITS - 1)) begin
                        state_d.cnt = '0;
                        state_d.bc  = '0;
                        state_d.ph  = PH_RDATA;
                    end else begin
                        state_d.cnt = state_q.cnt + 1'b1;
                    end
                end
                PH_WDATA: begin
                    state_d.sh = shifted;
                    state_d.bc = state_q.bc + 1'b1;
                    if (state_q.bc == 3'd7) begin
                        state_d.we    = 1'b1;
                        state_d.wsel  = state_q.sel;
                        state_d.waddr = state_q.addr;
                        state_d.wdata = shifted[7:0];
                        state_d.addr  = step(state_q.addr);
                    end
                end
                default: ;
            endcase
        end else if (sck_fall) begin
            unique case (state_q.ph)
                PH_RDATA: begin
                    state_d.so = rdata[3'd7 - state_q.bc];
                    state_d.oe = 1'b1;
                    state_d.bc = state_q.bc + 1'b1;
                    if (state_q.bc == 3'd7) state_d.addr = step(state_q.addr);
                end
                PH_STAT: begin
                    if (state_q.bc == 3'd0) begin
                        state_d.shadow = live;
                        state_d.so     = live[7];
                    end else begin
                        state_d.so = state_q.shadow[3'd7 - state_q.bc];
                    end
                    state_d.oe = 1'b1;
                    state_d.bc = state_q.bc + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.ph <= PH_OPC;
        end else begin
            state_q <= state_d;
        end
    end

    assign raddr = state_q.addr;
    assign rsel  = state_q.sel;
    assign we    = state_q.we;
    assign wsel  = state_q.wsel;
    assign waddr = state_q.waddr;
    assign wdata = state_q.wdata;
    assign so_o  = state_q.so;
    assign oe_o  = state_q.oe;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !oe_o);
    assert_so_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_hi) |=> $stable(so_o));
    assert_write_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(sck_rise));
    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.addr <= LAST);
    assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ph == PH_IGNORE) |-> (!oe_o && !we));

endmodule

// File: rtl/spi_pagebuf_slave.sv
module spi_pagebuf_slave
    import spi_pb_pkg::*;
#(
    parameter int         DEPTH      = 264,
    parameter int         RSV_BITS   = 15,
    parameter int         DUMMY_BITS = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] DENSITY    = 3'b011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe,
    input  logic status_ready,
    input  logic status_cmp_miss
);

    localparam int AW = $clog2(DEPTH);

    logic [2:0]    pin_lvl;
    logic [2:0]    pin_dly;
    logic          unused_dly;
    logic          sck_rise, sck_fall;
    logic [AW-1:0] raddr, waddr;
    logic          rsel, we, wsel;
    logic [7:0]    wdata, rdata;
    logic [7:0]    rd_arr [NBUF];

    spi_pb_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sck, spi_si}),
        .lvl_o   (pin_lvl),
        .dly_o   (pin_dly)
    );

    assign unused_dly = pin_dly[2] ^ pin_dly[0];
    assign sck_rise   =  pin_lvl[1] & ~pin_dly[1];
    assign sck_fall   = ~pin_lvl[1] &  pin_dly[1];

    spi_pb_ctrl #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .RSV_BITS   (RSV_BITS),
        .DUMMY_BITS (DUMMY_BITS),
        .DENSITY    (DENSITY)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (pin_lvl[2]),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si       (pin_lvl[0]),
        .ready    (status_ready),
        .cmp_miss (status_cmp_miss),
        .rdata    (rdata),
        .raddr    (raddr),
        .rsel     (rsel),
        .we       (we),
        .wsel     (wsel),
        .waddr    (waddr),
        .wdata    (wdata),
        .so_o     (spi_so),
        .oe_o     (spi_so_oe)
    );

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            spi_pb_ram #(
                .DEPTH (DEPTH),
                .AW    (AW),
                .DW    (8)
            ) u_ram (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we && (wsel == 1'(g))),
                .waddr (waddr),
                .wdata (wdata),
                .raddr (raddr),
                .rdata (rd_arr[g])
            );
        end
    endgenerate

    assign rdata = rd_arr[rsel];

endmodule

// File: tb/spi_pagebuf_slave_test.sv
module spi_pagebuf_slave_test;

    localparam int DEPTH = 264;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, so_oe;
    logic ready = 1'b1;
    logic miss = 1'b0;
    logic m3 = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mdl [2][DEPTH];

    always #2 clk = ~clk;

    spi_pagebuf_slave uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .spi_sck         (sck),
        .spi_cs_n        (cs_n),
        .spi_si          (si),
        .spi_so          (so),
        .spi_so_oe       (so_oe),
        .status_ready    (ready),
        .status_cmp_miss (miss)
    );

    function automatic int nxt(input int a);
        return (a == DEPTH - 1) ? 0 : a + 1;
    endfunction

    function automatic int norm(input int a);
        return (a >= DEPTH) ? 0 : a;
    endfunction

    function automatic logic [7:0] stat_exp(input logic r, input logic m);
        return {r, m, 3'b011, 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bitx(input logic b, output logic r, output logic e);
        sck = 1'b0;
        si  = b;
        repeat (HALF) @(negedge clk);
        r = so;
        e = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic begin_x();
        sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_x();
        if (!m3) sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic r, e;
        for (int i = 7; i >= 0; i--) bitx(b[i], r, e);
    endtask

    task automatic send_addr(input int a);
        logic [23:0] f;
        f = {15'd0, 9'(a)};
        send_byte(f[23:16]);
        send_byte(f[15:8]);
        send_byte(f[7:0]);
    endtask

    task automatic recv_byte(output logic [7:0] v, output bit all_on);
        logic r, e;
        all_on = 1;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b0, r, e);
            v[i] = r;
            if (e !== 1'b1) all_on = 0;
        end
    endtask

    task automatic do_write(input int b, input int a, input int n, input string req);
        int p;
        logic [7:0] d;
        begin_x();
        send_byte(b ? 8'h87 : 8'h84);
        send_addr(a);
        p = norm(a);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d);
            mdl[b][p] = d;
            p = nxt(p);
        end
        end_x();
    endtask

    task automatic do_read(input int b, input int a, input int n, input string req);
        int p;
        logic [7:0] v;
        logic [7:0] op;
        bit on;
        op = b ? 8'h56 : 8'h54;
        if ($urandom % 2) op[7] = 1'b1;
        begin_x();
        send_byte(op);
        send_addr(a);
        send_byte(8'($urandom));
        p = norm(a);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, on);
            check(on && (v === mdl[b][p]), req, int'(v), int'(mdl[b][p]));
            p = nxt(p);
        end
        end_x();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic r, e;
        bit on, quiet;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state, output disabled
        check(so_oe === 1'b0, "R1", int'(so_oe), 0);

        // R3 / R11: fill both buffers completely, mode 0 then mode 3
        m3 = 1'b0;
        do_write(0, 0, DEPTH, "R3");
        m3 = 1'b1;
        do_write(1, 0, DEPTH, "R11");

        // R4 / R2: read back in both clock modes
        m3 = 1'b0;
        do_read(0, 5, 4, "R4");
        m3 = 1'b1;
        do_read(1, 100, 4, "R2");

        // R5: write across the last byte, read across the end
        m3 = 1'b0;
        do_write(1, 262, 4, "R5");
        do_read(1, 260, 8, "R5");
        do_read(0, 263, 3, "R5");

        // R6: partial byte dropped, neighbours keep contents
        begin_x();
        send_byte(8'h87);
        send_addr(10);
        v = 8'($urandom);
        send_byte(v);
        mdl[1][10] = v;
        for (int i = 0; i < 5; i++) bitx(~mdl[1][11][7 - i], r, e);
        end_x();
        do_read(1, 9, 4, "R6");

        // R10: start address beyond the buffer maps to 0
        do_write(0, 300, 2, "R10");
        do_read(0, 400, 3, "R10");

        // R11: buffer B at the same spot was not touched by A writes
        do_read(1, 0, 2, "R11");

        // R7 / R8: status byte, repeated, flags changed mid-byte
        ready = 1'b1;
        miss  = 1'b0;
        m3 = 1'b1;
        begin_x();
        send_byte(8'hD7);
        recv_byte(v, on);
        check(on && v === stat_exp(1'b1, 1'b0), "R7", int'(v), int'(stat_exp(1'b1, 1'b0)));
        for (int i = 7; i >= 0; i--) begin
            if (i == 3) begin
                ready = 1'b0;
                miss  = 1'b1;
            end
            bitx(1'b0, r, e);
            v[i] = r;
        end
        check(v === stat_exp(1'b1, 1'b0), "R8", int'(v), int'(stat_exp(1'b1, 1'b0)));
        recv_byte(v, on);
        check(on && v === stat_exp(1'b0, 1'b1), "R8", int'(v), int'(stat_exp(1'b0, 1'b1)));
        end_x();
        m3 = 1'b0;
        begin_x();
        send_byte(8'h57);
        recv_byte(v, on);
        check(on && v === stat_exp(1'b0, 1'b1), "R7", int'(v), int'(stat_exp(1'b0, 1'b1)));
        end_x();
        ready = 1'b1;
        miss  = 1'b0;

        // R1: activity with chip select high is ignored
        quiet = 1;
        cs_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] junk;
            junk = (k == 0) ? 8'h84 : 8'($urandom);
            for (int i = 7; i >= 0; i--) begin
                bitx(junk[i], r, e);
                if (e !== 1'b0) quiet = 0;
            end
        end
        sck = 1'b0;
        repeat (3 * HALF) @(negedge clk);
        check(quiet, "R1", int'(!quiet), 0);
        do_read(0, 0, 4, "R1");

        // R9: unknown command stays silent and writes nothing
        quiet = 1;
        begin_x();
        send_byte(8'h11);
        for (int k = 0; k < 6; k++) begin
            for (int i = 7; i >= 0; i--) begin
                bitx(1'b1, r, e);
                if (e !== 1'b0) quiet = 0;
            end
        end
        end_x();
        check(quiet, "R9", int'(!quiet), 0);
        do_read(0, 0, 2, "R9");
        do_read(1, DEPTH - 1, 2, "R9");

        // R3 / R4 / R5: constrained random bursts
        for (int t = 0; t < 8; t++) begin
            int b, a, n;
            m3 = 1'($urandom);
            b  = int'($urandom % 2);
            a  = int'($urandom % DEPTH);
            n  = 1 + int'($urandom % 20);
            do_write(b, a, n, "R3");
            m3 = 1'($urandom);
            b  = int'($urandom % 2);
            a  = int'($urandom % DEPTH);
            n  = 1 + int'($urandom % 20);
            do_read(b, a, n, "R4");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule